// File: doc/BRIEF.md
# Serial Flash Status Register Command Unit

This block is the status-register front end of a serial flash slave port. It watches the chip-select, serial clock and serial data-in lines and decodes four commands: write enable, write disable, status read and status write. It keeps the status flags: the write-enable latch, the protection-register lock bit and the busy indication. It also tells an outside protection block when a whole-array protect or unprotect has been requested.

All three serial lines are oversampled by a fast system clock through a synchronizer of configurable depth. The link runs in SPI mode 0. Data-in is taken on the rising serial clock edge, and data-out changes on the falling edge. A status write does not change any state while it is being shifted in. It takes effect in the system-clock cycle after the synchronized chip-select is seen to rise. Program and erase engines are outside this block. They appear only as a level input for the busy flag and a one-cycle completion strobe, which clears the write-enable latch.

During a status read, the status byte is sent most significant bit first. A new snapshot is taken at the start of every byte for as long as the host keeps clocking, so the host can poll the busy bit until it falls.

Top module: `spi_status_unit`

## Requirements
- R1: After reset, a status read returns 8'h00. The data-out enable is low.
- R2: Opcode 8'h06, completed and followed by chip-select rising, sets the write-enable latch (status bit 1). Opcode 8'h04 clears it in the same way.
- R3: Opcode 8'h05 streams the status byte on data-out, MSB first. The layout is lock bit at bit 7, write-enable latch at bit 1 and busy at bit 0, with all other bits 0. The byte repeats for every further eight clocks, and each repetition uses the current state.
- R4: Opcode 8'h01 followed by one data byte, while the write-enable latch is 1, loads the lock bit from data bit 7 and clears the latch when chip-select rises. Any bytes after the first data byte have no effect.
- R5: Opcode 8'h01 while the write-enable latch is 0 changes neither the lock bit nor the latch.
- R6: An accepted status write raises a one-cycle protect request if data bits 5..2 are 4'b1111 and the lock bit was 0 before the command. It raises a one-cycle unprotect request if those bits are 4'b0000 and the lock bit was 0. It raises no request in any other case.
- R7: If chip-select rises before all eight opcode bits have been received, the write-enable latch keeps its value.
- R8: If a complete status-write opcode is received but chip-select rises before the data byte is complete, the latch is cleared and the lock bit is unchanged.
- R9: A one-cycle pulse on the completion input clears the write-enable latch.
- R10: The data-out enable is high only during the data phase of a status read. It drops once chip-select is deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock from the host |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| so_oe | output | 1 | Drive enable for so; low means high impedance |
| busy_in | input | 1 | Level from the program/erase engine, reported as the busy bit |
| op_done | input | 1 | One-cycle strobe marking the end of a program or erase |
| glob_prot_req | output | 1 | One-cycle request to protect the whole array |
| glob_unprot_req | output | 1 | One-cycle request to unprotect the whole array |

## Verification
The bench aborts transactions after three opcode bits, and again right after a full status-write opcode. A design that cleared the latch on any deassertion would fail the first case. A design that waited for the data byte would fail the second. The global request tests use the old lock bit together with a new value that differs from it. A design that decided using the new lock bit would send requests in the wrong cases. One status read spans three bytes while the busy input falls in the middle. A design that latched the byte only once at the opcode would keep reporting busy.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;

   typedef enum logic [7:0] {
      OP_WRSR = 8'h01,
      OP_WRDI = 8'h04,
      OP_RDSR = 8'h05,
      OP_WREN = 8'h06
   } sr_op_e;

   localparam int unsigned SR_W       = 8;
   localparam int unsigned LOCK_POS   = 7;
   localparam int unsigned WEL_POS    = 1;
   localparam int unsigned BUSY_POS   = 0;
   localparam int unsigned GSEL_HI    = 5;
   localparam int unsigned GSEL_LO    = 2;
   localparam int unsigned GSEL_W     = GSEL_HI - GSEL_LO + 1;

endpackage

// File: rtl/spi_sr_sync.sv
module spi_sr_sync #(
   parameter int unsigned STAGES    = 2,
   parameter int unsigned WIDTH     = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("spi_sr_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] pipe_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[s] <= RST_VAL;
               else        pipe_q[s] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe_q[s] <= RST_VAL;
               else        pipe_q[s] <= pipe_q[s-1];
            end
         end
      end
   endgenerate

   assign d_out = pipe_q[STAGES-1];

endmodule

// File: rtl/spi_sr_rx.sv
module spi_sr_rx #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned MAX_BYTES = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cs_on,
   input  logic                          cs_act,
   input  logic                          sck_rise,
   input  logic                          si_s,
   output logic                          byte_vld,
   output logic [BYTE_W-1:0]             byte_data,
   output logic [$clog2(MAX_BYTES+1)-1:0] byte_idx
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);
   localparam int unsigned IDX_W = $clog2(MAX_BYTES + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] IDX_SAT  = IDX_W'(MAX_BYTES);

   generate
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_w
         $error("spi_sr_rx: BYTE_W must be a power of two");
      end
   endgenerate

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] shreg;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
         shreg   <= '0;
         idx_q   <= '0;
      end else if (cs_on) begin
         bit_cnt <= '0;
         idx_q   <= '0;
      end else if (sck_rise && cs_act) begin
         shreg   <= {shreg[BYTE_W-3:0], si_s};
         bit_cnt <= bit_cnt + 1'b1;
         if (bit_cnt == LAST_BIT && idx_q != IDX_SAT)
            idx_q <= idx_q + 1'b1;
      end
   end

   assign byte_vld  = sck_rise && cs_act && (bit_cnt == LAST_BIT);
   assign byte_data = {shreg, si_s};
   assign byte_idx  = idx_q;

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_rise && !cs_act) |=> $stable(bit_cnt));

endmodule

// File: rtl/spi_sr_ctrl.sv
module spi_sr_ctrl
   import spi_sr_pkg::*;
#(
   parameter int unsigned IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_on,
   input  logic             cs_off,
   input  logic             byte_vld,
   input  logic [SR_W-1:0]  byte_data,
   input  logic [IDX_W-1:0] byte_idx,
   input  logic             busy_in,
   input  logic             op_done,
   output logic [SR_W-1:0]  status,
   output logic             rd_active,
   output logic             gprot,
   output logic             gunprot
);

   logic [SR_W-1:0] opc_q;
   logic [SR_W-1:0] dat_q;
   logic            opc_full;
   logic            dat_full;
   logic            wel_q;
   logic            lock_q;
   logic            busy_q;
   logic [GSEL_W-1:0] gsel;

   assign gsel = dat_q[GSEL_HI:GSEL_LO];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opc_q     <= '0;
         dat_q     <= '0;
         opc_full  <= 1'b0;
         dat_full  <= 1'b0;
         wel_q     <= 1'b0;
         lock_q    <= 1'b0;
         busy_q    <= 1'b0;
         rd_active <= 1'b0;
         gprot     <= 1'b0;
         gunprot   <= 1'b0;
      end else begin
         gprot   <= 1'b0;
         gunprot <= 1'b0;
         busy_q  <= busy_in;
         if (cs_on) begin
            opc_full  <= 1'b0;
            dat_full  <= 1'b0;
            rd_active <= 1'b0;
         end else if (byte_vld) begin
            if (byte_idx == '0) begin
               opc_q    <= byte_data;
               opc_full <= 1'b1;
               if (byte_data == OP_RDSR) rd_active <= 1'b1;
            end else if (byte_idx == IDX_W'(1) && opc_q == OP_WRSR) begin
               dat_q    <= byte_data;
               dat_full <= 1'b1;
            end
         end
         if (cs_off) begin
            rd_active <= 1'b0;
            if (opc_full) begin
               case (opc_q)
                  OP_WREN: wel_q <= 1'b1;
                  OP_WRDI: wel_q <= 1'b0;
                  OP_WRSR: begin
                     if (wel_q) begin
                        wel_q <= 1'b0;
                        if (dat_full) begin
                           lock_q <= dat_q[LOCK_POS];
                           if (!lock_q && gsel == '1) gprot   <= 1'b1;
                           if (!lock_q && gsel == '0) gunprot <= 1'b1;
                        end
                     end
                  end
                  default: ;
               endcase
            end
         end
         if (op_done) wel_q <= 1'b0;
      end
   end

   always_comb begin
      status           = '0;
      status[LOCK_POS] = lock_q;
      status[WEL_POS]  = wel_q;
      status[BUSY_POS] = busy_q;
   end

   // R7
   wel_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_off && !opc_full && !op_done) |=> (wel_q == $past(wel_q)));

   // R5
   wrsr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_off && opc_full && opc_q == OP_WRSR && !wel_q) |=> $stable(lock_q));

   // R6
   gp_prior_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gprot || gunprot) |-> !$past(lock_q));

   // R6
   gp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gprot && gunprot));

   // R9
   done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_done |=> !wel_q);

   // R10
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_off |=> !rd_active);

endmodule

// File: rtl/spi_sr_tx.sv
module spi_sr_tx #(
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_on,
   input  logic              sck_fall,
   input  logic              rd_active,
   input  logic [BYTE_W-1:0] status,
   output logic              so,
   output logic              so_oe
);

   localparam int unsigned CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  tx_cnt;
   logic [BYTE_W-1:0] tx_buf;
   logic              so_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_cnt <= '0;
         tx_buf <= '0;
         so_q   <= 1'b0;
      end else if (cs_on) begin
         tx_cnt <= '0;
         so_q   <= 1'b0;
      end else if (sck_fall && rd_active) begin
         tx_cnt <= tx_cnt + 1'b1;
         if (tx_cnt == '0) begin
            so_q   <= status[BYTE_W-1];
            tx_buf <= {status[BYTE_W-2:0], 1'b0};
         end else begin
            so_q   <= tx_buf[BYTE_W-1];
            tx_buf <= {tx_buf[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign so    = so_q;
   assign so_oe = rd_active;

   // R3
   tx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_active && !cs_on) |=> $stable(tx_cnt));

endmodule

// File: rtl/spi_status_unit.sv
module spi_status_unit
   import spi_sr_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MAX_BYTES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic sck,
   input  logic si,
   output logic so,
   output logic so_oe,
   input  logic busy_in,
   input  logic op_done,
   output logic glob_prot_req,
   output logic glob_unprot_req
);

   localparam int unsigned IDX_W = $clog2(MAX_BYTES + 1);

   generate
      if (MAX_BYTES < 2) begin : g_bad_bytes
         $error("spi_status_unit: MAX_BYTES must cover opcode and data");
      end
   endgenerate

   logic [2:0] pins_s;
   logic cs_s, sck_s, si_s;
   logic cs_d, sck_d;
   logic cs_on, cs_off, cs_act, sck_rise, sck_fall;
   logic              byte_vld;
   logic [SR_W-1:0]   byte_data;
   logic [IDX_W-1:0]  byte_idx;
   logic [SR_W-1:0]   status;
   logic              rd_active;

   spi_sr_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d_in ({cs_n, sck, si}),
      .d_out(pins_s)
   );

   assign {cs_s, sck_s, si_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_d  <= 1'b1;
         sck_d <= 1'b0;
      end else begin
         cs_d  <= cs_s;
         sck_d <= sck_s;
      end
   end

   assign cs_act   = !cs_s;
   assign cs_on    = !cs_s && cs_d;
   assign cs_off   = cs_s && !cs_d;
   assign sck_rise = sck_s && !sck_d;
   assign sck_fall = !sck_s && sck_d;

   spi_sr_rx #(
      .BYTE_W   (SR_W),
      .MAX_BYTES(MAX_BYTES)
   ) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_on    (cs_on),
      .cs_act   (cs_act),
      .sck_rise (sck_rise),
      .si_s     (si_s),
      .byte_vld (byte_vld),
      .byte_data(byte_data),
      .byte_idx (byte_idx)
   );

   spi_sr_ctrl #(
      .IDX_W(IDX_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_on    (cs_on),
      .cs_off   (cs_off),
      .byte_vld (byte_vld),
      .byte_data(byte_data),
      .byte_idx (byte_idx),
      .busy_in  (busy_in),
      .op_done  (op_done),
      .status   (status),
      .rd_active(rd_active),
      .gprot    (glob_prot_req),
      .gunprot  (glob_unprot_req)
   );

   spi_sr_tx #(
      .BYTE_W(SR_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_on    (cs_on),
      .sck_fall (sck_fall),
      .rd_active(rd_active),
      .status   (status),
      .so       (so),
      .so_oe    (so_oe)
   );

   // R10
   oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> (cs_act || cs_off));

endmodule

// File: tb/spi_status_unit_bench.sv
module spi_status_unit_bench;

   localparam int HP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1;
   logic sck = 1'b0;
   logic si = 1'b0;
   logic busy_in = 1'b0;
   logic op_done = 1'b0;
   logic so, so_oe, gp, gu;

   int total = 0;
   int bad = 0;
   int gp_cnt = 0;
   int gu_cnt = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   spi_status_unit u_spi_status_unit (
      .clk            (clk),
      .rst_n          (rst_n),
      .cs_n           (cs_n),
      .sck            (sck),
      .si             (si),
      .so             (so),
      .so_oe          (so_oe),
      .busy_in        (busy_in),
      .op_done        (op_done),
      .glob_prot_req  (gp),
      .glob_unprot_req(gu)
   );

   always @(posedge clk) begin
      if (gp) gp_cnt <= gp_cnt + 1;
      if (gu) gu_cnt <= gu_cnt + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cs_start();
      @(negedge clk); cs_n = 1'b0;
      wclk(HP);
   endtask

   task automatic cs_end();
      wclk(HP);
      cs_n = 1'b1;
      wclk(12);
   endtask

   task automatic xbit(input logic b, output logic r);
      si = b;
      wclk(HP);
      r = so;
      sck = 1'b1;
      wclk(HP);
      sck = 1'b0;
   endtask

   task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
      for (int i = 7; i >= 0; i--) begin
         logic b;
         xbit(d[i], b);
         r[i] = b;
      end
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      cs_start(); xbyte(op, r); cs_end();
   endtask

   task automatic wrsr(input logic [7:0] d);
      logic [7:0] r;
      cs_start(); xbyte(8'h01, r); xbyte(d, r); cs_end();
   endtask

   task automatic rdsr(output logic [7:0] s);
      logic [7:0] r;
      cs_start(); xbyte(8'h05, r); xbyte(8'h00, s); cs_end();
   endtask

   task automatic t_reset();
      logic [7:0] s;
      check(so_oe === 1'b0, "R1 oe at reset", so_oe, 0);
      rdsr(s);
      check(s === 8'h00, "R1 reset status", s, 8'h00);
   endtask

   task automatic t_wren_wrdi();
      logic [7:0] s;
      cmd1(8'h06); rdsr(s);
      check(s === 8'h02, "R2 wren sets latch", s, 8'h02);
      cmd1(8'h04); rdsr(s);
      check(s === 8'h00, "R2 wrdi clears latch", s, 8'h00);
   endtask

   task automatic t_rdsr_repeat();
      logic [7:0] r, s0, s1, s2;
      cmd1(8'h06);
      busy_in = 1'b1;
      wclk(4);
      cs_start(); xbyte(8'h05, r);
      check(so_oe === 1'b1, "R10 oe in read phase", so_oe, 1);
      xbyte(8'h00, s0);
      xbyte(8'h00, s1);
      busy_in = 1'b0;
      xbyte(8'h00, s2);
      cs_end();
      check(s0 === 8'h03, "R3 first byte busy", s0, 8'h03);
      check(s1 === 8'h03, "R3 repeat byte", s1, 8'h03);
      check(s2 === 8'h02, "R3 live busy drop", s2, 8'h02);
      check(so_oe === 1'b0, "R10 oe after cs high", so_oe, 0);
      cmd1(8'h04);
   endtask

   task automatic t_wrsr_basic();
      logic [7:0] s, r;
      cmd1(8'h06);
      wrsr(8'h80);
      rdsr(s);
      check(s === 8'h80, "R4 lock set, latch cleared", s, 8'h80);
      cmd1(8'h06);
      cs_start(); xbyte(8'h01, r); xbyte(8'h00, r); xbyte(8'hFF, r); cs_end();
      rdsr(s);
      check(s === 8'h00, "R4 extra byte ignored", s, 8'h00);
   endtask

   task automatic t_locked();
      logic [7:0] s;
      wrsr(8'h80);
      rdsr(s);
      check(s === 8'h00, "R5 write without latch", s, 8'h00);
   endtask

   task automatic t_global();
      logic [7:0] s;
      int g0, u0;
      g0 = gp_cnt; u0 = gu_cnt;
      cmd1(8'h06); wrsr(8'h3C);
      check(gp_cnt - g0 == 1 && gu_cnt == u0, "R6 protect pulse", gp_cnt - g0, 1);
      g0 = gp_cnt; u0 = gu_cnt;
      cmd1(8'h06); wrsr(8'h14);
      check(gp_cnt == g0 && gu_cnt == u0, "R6 mixed bits no request", gp_cnt - g0 + gu_cnt - u0, 0);
      g0 = gp_cnt; u0 = gu_cnt;
      cmd1(8'h06); wrsr(8'h80);
      check(gu_cnt - u0 == 1 && gp_cnt == g0, "R6 unprotect pulse", gu_cnt - u0, 1);
      g0 = gp_cnt; u0 = gu_cnt;
      cmd1(8'h06); wrsr(8'h3C);
      check(gp_cnt == g0 && gu_cnt == u0, "R6 prior lock blocks", gp_cnt - g0 + gu_cnt - u0, 0);
      rdsr(s);
      check(s === 8'h00, "R6 lock reloaded", s, 8'h00);
   endtask

   task automatic t_partial();
      logic [7:0] s;
      logic b;
      cmd1(8'h06);
      cs_start(); xbit(1'b0, b); xbit(1'b0, b); xbit(1'b0, b); cs_end();
      rdsr(s);
      check(s === 8'h02, "R7 partial opcode keeps latch", s, 8'h02);
   endtask

   task automatic t_abort();
      logic [7:0] s, r;
      logic b;
      cmd1(8'h06); wrsr(8'h80);
      cmd1(8'h06);
      cs_start(); xbyte(8'h01, r); xbit(1'b0, b); xbit(1'b0, b); cs_end();
      rdsr(s);
      check(s === 8'h80, "R8 abort clears latch, keeps lock", s, 8'h80);
      cmd1(8'h06); wrsr(8'h00);
   endtask

   task automatic t_opdone();
      logic [7:0] s;
      cmd1(8'h06);
      @(negedge clk); op_done = 1'b1;
      @(negedge clk); op_done = 1'b0;
      rdsr(s);
      check(s === 8'h00, "R9 completion clears latch", s, 8'h00);
   endtask

   task automatic t_oe_idle();
      logic [7:0] r;
      cs_start(); xbyte(8'h06, r);
      check(so_oe === 1'b0, "R10 no drive outside read", so_oe, 0);
      cs_end();
      cmd1(8'h04);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      t_reset();
      t_wren_wrdi();
      t_rdsr_repeat();
      t_wrsr_basic();
      t_locked();
      t_global();
      t_partial();
      t_abort();
      t_opdone();
      t_oe_idle();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule